// File: doc/BRIEF.md
# Latched Fault Protection Controller

This block guards a chopper-driven stepper output stage against overcurrent and overheating. It watches two comparator inputs, one for winding current and one for substrate temperature. When either reports a sustained problem it latches a fault. The latched fault forces a drive-kill signal high, which turns off every power output, and it pulls an active-low fault flag low for an open-drain pin.

Ringing right after each switch turn-on can look like an overcurrent. For that reason the overcurrent path ignores its comparator for a programmable number of clock cycles after every conduction-start strobe from the chopper. The overheat path is never masked. Both comparator inputs pass through a synchroniser. Each must then hold high for two consecutive clock samples before it counts as a detection.

A latched fault does not clear when the condition goes away. Only the power-on reset input or a low pulse on the active-low reset input clears it. A 2-bit cause value records which protection tripped first, so that tests can observe it.

Top module: `fault_guard`

## Requirements
- R1: While `por` is high or `rst_n` is low, `kill` is 1. After reset is released, `kill` is 0, `fault_n` is 1 and `cause` is 2'b00 until a fault trips.
- R2: A high level on `oc_cmp` that is sampled at only one clock edge never trips a fault. A level sampled high at two or more consecutive edges outside the blanking window does trip one.
- R3: `ot_cmp` needs the same two-sample qualification as `oc_cmp`, and it is never blanked. A strobe on `pwm_on` has no effect on it.
- R4: Let `pwm_on` be sampled high at edge 0, and let `oc_cmp` be sampled high at edges D to D+W-1 and low at all other edges. A fault then trips exactly when W >= 2 and D+W >= BLANK_CYCLES.
- R5: Each `pwm_on` strobe restarts the blanking window from its full length, even if a window is already running.
- R6: Once a fault has tripped, `fault_n` stays 0 and `kill` stays 1 after both comparator inputs return low. They hold until a reset.
- R7: `cause` records the first trip only. 2'b01 means overcurrent, 2'b10 means overheat, and 2'b11 means both qualified in the same cycle. A later detection of the other kind leaves `cause` unchanged.
- R8: Either reset source clears the latch and `cause`: a single low cycle on `rst_n`, or a single high cycle on `por`.
- R9: If an unblanked comparator is sampled high at edges k and k+1, `fault_n` is still 1 after edge k+2 and falls to 0 after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously; a low pulse clears a latched fault |
| por | input | 1 | Power-on reset, active high, sampled synchronously |
| pwm_on | input | 1 | One-cycle strobe marking each start of chopper conduction |
| oc_cmp | input | 1 | Overcurrent comparator output, asynchronous |
| ot_cmp | input | 1 | Overtemperature comparator output, asynchronous |
| kill | output | 1 | Forces all drive outputs off while high |
| fault_n | output | 1 | Active-low fault flag for an open-drain pin |
| cause | output | 2 | First-trip cause: 01 overcurrent, 10 overheat, 11 both |

## Verification
The overcurrent path gets a near-exhaustive sweep over the start offset D and the pulse width W, measured from a strobe, with a short blanking window. The bench compares each outcome with the arithmetic rule D+W >= BLANK_CYCLES and W >= 2. This separates errors at the blanking boundary, in the width qualification and in the strobe timing. Doubled strobes show whether the window restarts rather than runs on. Single-cycle and two-cycle overheat pulses placed right after a strobe show that the qualification applies to overheat but the blanking does not. Fault sequences first in one order, then the other, then simultaneously show whether the cause value freezes and how a tie is encoded. Clearing through each reset source, and the edge on which a fault first appears, are checked separately.

// File: rtl/fg_pkg.sv
// Shared types for the latched fault protection controller.
// Assumes: nothing beyond the enum encoding below, which is visible at the top's ports.
package fg_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_OC   = 2'b01,
        CAUSE_OT   = 2'b10,
        CAUSE_BOTH = 2'b11
    } cause_e;
endpackage

// File: rtl/fg_qualifier.sv
// Synchronises one asynchronous comparator level and qualifies it.
// det_o is high once the synchronised level has been high for QUAL_CYCLES
// consecutive clock samples.
// Assumes: SYNC_STAGES >= 2, QUAL_CYCLES >= 2, synchronous active-low reset.
module fg_qualifier #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic det_o
);
    localparam int HIST_W = QUAL_CYCLES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST_W-1:0]      hist_q;
    logic                   sync_lvl;

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    // Purpose: metastability chain that brings the comparator into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    generate
        if (HIST_W == 1) begin : g_hist1
            // Purpose: remember the previous synchronised sample.
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= sync_lvl;
            end
        end else begin : g_histn
            // Purpose: shift history of previous synchronised samples.
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= {hist_q[HIST_W-2:0], sync_lvl};
            end
        end
    endgenerate

    // Purpose: detection needs the current and all remembered samples high.
    always_comb det_o = sync_lvl & (&hist_q);
endmodule

// File: rtl/fg_blanker.sv
// Produces the overcurrent blanking window. Every strobe reloads a down-counter
// with BLANK_CYCLES, and the window stays open while the counter is non-zero or a
// strobe is present.
// Assumes: strobe_i is synchronous to clk; BLANK_CYCLES >= 1.
module fg_blanker #(
    parameter int BLANK_CYCLES = 688
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic blank_o
);
    localparam int CNT_W = $clog2(BLANK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BLANK_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: reload on each strobe, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (strobe_i)     cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Purpose: the window is open during the strobe and while the count runs.
    always_comb blank_o = strobe_i | (cnt_q != '0);
endmodule

// File: rtl/fg_trip_latch.sv
// Sticky fault latch with first-cause capture. The latch sets on the first cycle
// with any hit, and only reset clears it. The cause is captured in that same cycle
// and then frozen.
// Assumes: hits are already qualified and blanked upstream.
module fg_trip_latch
    import fg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   oc_hit_i,
    input  logic   ot_hit_i,
    output logic   tripped_o,
    output cause_e cause_o
);
    // Purpose: set once on the first hit, record which hits were present, hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tripped_o <= 1'b0;
            cause_o   <= CAUSE_NONE;
        end else if (!tripped_o && (oc_hit_i || ot_hit_i)) begin
            tripped_o <= 1'b1;
            cause_o   <= cause_e'({ot_hit_i, oc_hit_i});
        end
    end
endmodule

// File: rtl/fault_guard.sv
// Top of the latched fault protection controller. Two comparator channels are
// qualified, the overcurrent channel is blanked after each conduction start,
// and any surviving hit latches a fault that kills the drives.
// Assumes: rst_n and por are sampled synchronously; pwm_on is a one-cycle
// strobe synchronous to clk.
module fault_guard
    import fg_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_CYCLES  = 2,
    parameter int BLANK_CYCLES = 688
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por,
    input  logic       pwm_on,
    input  logic       oc_cmp,
    input  logic       ot_cmp,
    output logic       kill,
    output logic       fault_n,
    output logic [1:0] cause
);
    localparam int N_CH  = 2;
    localparam int CH_OC = 0;
    localparam int CH_OT = 1;

    logic            core_rst_n;
    logic [N_CH-1:0] raw_vec;
    logic [N_CH-1:0] det_vec;
    logic            oc_blank;
    logic            tripped;
    cause_e          cause_q;

    // Purpose: either reset source holds the whole block in reset.
    always_comb core_rst_n = rst_n & ~por;

    assign raw_vec[CH_OC] = oc_cmp;
    assign raw_vec[CH_OT] = ot_cmp;

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            fg_qualifier #(
                .SYNC_STAGES (SYNC_STAGES),
                .QUAL_CYCLES (QUAL_CYCLES)
            ) u_qual (
                .clk   (clk),
                .rst_n (core_rst_n),
                .raw_i (raw_vec[ch]),
                .det_o (det_vec[ch])
            );
        end
    endgenerate

    fg_blanker #(
        .BLANK_CYCLES (BLANK_CYCLES)
    ) u_blank (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .strobe_i (pwm_on),
        .blank_o  (oc_blank)
    );

    fg_trip_latch u_latch (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .oc_hit_i  (det_vec[CH_OC] & ~oc_blank),
        .ot_hit_i  (det_vec[CH_OT]),
        .tripped_o (tripped),
        .cause_o   (cause_q)
    );

    // Purpose: drives stay off while latched or while any reset is asserted.
    always_comb begin
        kill    = tripped | ~core_rst_n;
        fault_n = ~tripped;
        cause   = cause_q;
    end
endmodule

// File: rtl/fg_checker.sv
// Assertion checker for fault_guard, attached with bind below.
// Assumes: the blank input is the overcurrent blanking window of the top.
module fg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       por,
    input logic       blank,
    input logic       kill,
    input logic       fault_n,
    input logic [1:0] cause
);
    logic rst_req;
    logic prev_rst = 1'b0;

    assign rst_req = !rst_n || por;

    // Purpose: remember that the previous edge was in reset.
    always_ff @(posedge clk) prev_rst <= rst_req;

    // Purpose: immediate checks around reset (R1, R8).
    always_ff @(posedge clk) begin
        if (rst_req) begin
            a_r1_kill_in_reset: assert (kill);
        end
        if (prev_rst) begin
            a_r8_clear_after_reset: assert (fault_n && cause == 2'b00);
        end
    end

    a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst_req)
        !fault_n |=> !fault_n);

    a_r6_kill_with_fault: assert property (@(posedge clk) disable iff (rst_req)
        !fault_n |-> kill);

    a_r7_cause_frozen: assert property (@(posedge clk) disable iff (rst_req)
        !fault_n |=> $stable(cause));

    a_r7_cause_set: assert property (@(posedge clk) disable iff (rst_req)
        !fault_n |-> cause != 2'b00);

    a_r7_cause_clear: assert property (@(posedge clk) disable iff (rst_req)
        fault_n |-> cause == 2'b00);

    a_r4_no_blanked_trip: assert property (@(posedge clk) disable iff (rst_req)
        ($fell(fault_n) && cause[0]) |-> !$past(blank));
endmodule

bind fault_guard fg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .por     (por),
    .blank   (oc_blank),
    .kill    (kill),
    .fault_n (fault_n),
    .cause   (cause)
);

// File: tb/fault_guard_tb.sv
// Self-checking bench for fault_guard with a short blanking window.
module fault_guard_tb;
    localparam int BLANK = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       por = 1'b1;
    logic       pwm_on = 1'b0;
    logic       oc_cmp = 1'b0;
    logic       ot_cmp = 1'b0;
    logic       kill;
    logic       fault_n;
    logic [1:0] cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fault_guard #(.BLANK_CYCLES(BLANK)) u_dut (
        .clk(clk), .rst_n(rst_n), .por(por), .pwm_on(pwm_on),
        .oc_cmp(oc_cmp), .ot_cmp(ot_cmp),
        .kill(kill), .fault_n(fault_n), .cause(cause)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwm_on = 1'b0; oc_cmp = 1'b0; ot_cmp = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        @(negedge clk);
        // R1: power-on reset holds kill and a clean state
        tick();
        check("R1 kill in por", kill, 1);
        check("R1 fault_n in por", fault_n, 1);
        check("R1 cause in por", cause, 0);
        por = 1'b0;
        tick();
        check("R1 kill released", kill, 0);

        // R9: latency from first sample, no strobe
        do_reset();
        oc_cmp = 1'b1;
        tick(); tick(); tick();
        check("R9 not yet after edge 2", fault_n, 1);
        tick();
        check("R9 fault after edge 3", fault_n, 0);
        check("R7 cause overcurrent", cause, 1);

        // R6: latch holds after the condition goes away
        oc_cmp = 1'b0;
        repeat (20) tick();
        check("R6 fault held", fault_n, 0);
        check("R6 kill held", kill, 1);

        // R8: rst_n low pulse clears; R1 kill during reset
        rst_n = 1'b0;
        #1;
        check("R1 kill while rst_n low", kill, 1);
        tick();
        rst_n = 1'b1;
        tick();
        check("R8 rst_n clears fault", fault_n, 1);
        check("R8 rst_n clears cause", cause, 0);
        check("R8 kill off after rst_n", kill, 0);

        // R4 / R2: sweep offset and width after a strobe
        for (int d = 0; d <= 8; d++) begin
            for (int w = 1; w <= 8; w++) begin
                bit exp_trip;
                do_reset();
                for (int e = 0; e < d + w + 6; e++) begin
                    pwm_on = (e == 0);
                    oc_cmp = (e >= d) && (e < d + w);
                    tick();
                end
                pwm_on = 1'b0; oc_cmp = 1'b0;
                exp_trip = (w >= 2) && (d + w >= BLANK);
                check("R4 sweep fault_n", fault_n, exp_trip ? 0 : 1);
                check("R2 sweep cause", cause, exp_trip ? 1 : 0);
            end
        end

        // R5: second strobe restarts the window
        do_reset();
        for (int e = 0; e <= 10; e++) begin
            pwm_on = (e == 0) || (e == 3);
            oc_cmp = 1'b1;
            tick();
            if (e == 8) check("R5 still blanked after edge 8", fault_n, 1);
            if (e == 9) check("R5 still clear after edge 9", fault_n, 1);
            if (e == 10) check("R5 trips after edge 10", fault_n, 0);
        end
        pwm_on = 1'b0; oc_cmp = 1'b0;

        // R3: overheat is not blanked and needs two samples
        do_reset();
        pwm_on = 1'b1; ot_cmp = 1'b1;
        tick();
        pwm_on = 1'b0; ot_cmp = 1'b0;
        repeat (6) tick();
        check("R3 single ot sample ignored", fault_n, 1);
        pwm_on = 1'b1; ot_cmp = 1'b1;
        tick();
        pwm_on = 1'b0;
        tick();
        ot_cmp = 1'b0;
        repeat (4) tick();
        check("R3 ot trips inside window", fault_n, 0);
        check("R3 cause overheat", cause, 2);

        // R7: later overcurrent leaves cause at overheat
        oc_cmp = 1'b1;
        repeat (6) tick();
        oc_cmp = 1'b0;
        check("R7 cause frozen", cause, 2);

        // R8: por pulse clears
        por = 1'b1;
        tick();
        por = 1'b0;
        tick();
        check("R8 por clears fault", fault_n, 1);
        check("R8 por clears cause", cause, 0);

        // R7: simultaneous detection encodes both
        do_reset();
        oc_cmp = 1'b1; ot_cmp = 1'b1;
        repeat (5) tick();
        check("R7 cause both", cause, 3);
        oc_cmp = 1'b0; ot_cmp = 1'b0;

        // R7: overcurrent first then overheat
        do_reset();
        oc_cmp = 1'b1;
        repeat (5) tick();
        oc_cmp = 1'b0; ot_cmp = 1'b1;
        repeat (5) tick();
        ot_cmp = 1'b0;
        check("R7 cause stays overcurrent", cause, 1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule